// File: doc/BRIEF.md
# Privileged Status and Cause Control Registers

This block holds the two software-writable control words of a processor's system coprocessor: the Status word, which carries coprocessor-usable enables, privilege mode, address-space enables and reset indicators, and the Cause word, which carries the interrupt vector select, watch-pending, software interrupt requests and the counter disable. A single write port, made of an enable, a two-bit select and a data word, updates one of the two words per cycle. Each write is filtered by rules that depend on static configuration inputs: architecture release flags, supervisor-mode support and a 64-bit addressing enable.

Besides the stored words, the block produces the side effects that follow from a bit change. It pulses a stop or start request to the cycle counter when the counter-disable bit flips. It drives two software-interrupt request levels from the two low interrupt-pending bits. It issues a one-cycle TLB flush request when a 64-bit segment enable is withdrawn. It also maintains a per-thread status mirror that holds a copy of selected Status fields together with the current address-space identifier. All outputs are registered and appear in the cycle after the write.

Top module: `priv_ctl_regs`

## Requirements
- R1: During and after reset, `status_q` equals the parameter STATUS_RST, `cause_q` equals CAUSE_RST, `tc_status_q` equals MIRROR_RST, and `count_stop`, `count_start`, `swi_req` and `tlb_flush` are all 0.
- R2: A Cause write changes only bits 23, 22, 9 and 8, plus bit 27 (counter disable) when `cfg_r2` is 1; every other Cause bit keeps its value.
- R3: With `cfg_r6` = 1, a Cause write can clear bit 22 (watch pending) but never set it; with `cfg_r6` = 0 the bit is written normally.
- R4: When a Cause write flips bit 27, the next cycle shows `count_stop` = 1 if the bit became 1, or `count_start` = 1 if it became 0, for exactly one cycle; neither is raised otherwise.
- R5: When a Cause write flips bit 8 or bit 9, `swi_req[0]` or `swi_req[1]` respectively takes the new bit value and holds it until the next change.
- R6: A Status write produces (old & ~cfg_status_wmask) | (data & cfg_status_wmask), before the release-6 rules below narrow the mask.
- R7: With `cfg_r6` = 1, a Status write can clear bit 20 (soft reset) and bit 19 (non-maskable interrupt) but cannot set them.
- R8: With `cfg_r6` = 1 and `cfg_super` = 1, a Status write whose bits 4:3 are 2'b11 leaves Status bits 4:3 unchanged.
- R9: With `cfg_r6` = 1 and `cfg_64` = 1, written bit 6 is forced to 0 when written bit 7 is 0, and written bit 5 is forced to 0 when the resulting bit 6 is 0, before masking.
- R10: When a Status write clears any of bits 7, 6, 5 that was 1, `tlb_flush` is 1 for exactly the next cycle; otherwise it stays 0.
- R11: After each Status write, `tc_status_q` bits 31:28 copy Status 31:28, bit 27 copies Status bit 24, bits 12:11 copy Status 4:3, bits 7:0 copy `asid_in`; all other mirror bits keep their value.
- R12: `wr_sel` 2'b01 selects Status and 2'b10 selects Cause; a write with 2'b00 or 2'b11 changes no register and raises no pulse or request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target select: 01 Status, 10 Cause |
| wr_data | input | 32 | Write data |
| cfg_r6 | input | 1 | Release-6 write rules enable |
| cfg_r2 | input | 1 | Release-2 features (counter disable writable) |
| cfg_super | input | 1 | Supervisor mode implemented |
| cfg_64 | input | 1 | 64-bit segment enables present |
| cfg_status_wmask | input | 32 | Writable-bit mask of Status |
| asid_in | input | 8 | Current address-space identifier |
| status_q | output | 32 | Status word |
| cause_q | output | 32 | Cause word |
| tc_status_q | output | 32 | Per-thread status mirror |
| count_stop | output | 1 | One-cycle counter stop request |
| count_start | output | 1 | One-cycle counter start request |
| swi_req | output | 2 | Software interrupt request levels |
| tlb_flush | output | 1 | One-cycle TLB flush request |

## Verification
The bench builds the block with a Status reset value that has the soft-reset, non-maskable-interrupt and all three segment-enable bits set, and a Cause reset value with watch-pending set. This puts the clear-only bits in the 1 state straight out of reset, so the refusal to set them and the ability to clear them can both be seen, and the first Status write that removes a segment enable brings out the flush pulse. The writable mask is driven with bit 16 excluded so the masking rule is observable on a bit no other rule touches.

// File: rtl/priv_ctl_pkg.sv
package priv_ctl_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ASID_W  = 8;
  localparam int unsigned NUM_SWI = 2;

  // Status bit positions
  localparam int unsigned ST_CU_LO  = 28;
  localparam int unsigned ST_MX     = 24;
  localparam int unsigned ST_SR     = 20;
  localparam int unsigned ST_NMI    = 19;
  localparam int unsigned ST_KX     = 7;
  localparam int unsigned ST_SX     = 6;
  localparam int unsigned ST_UX     = 5;
  localparam int unsigned ST_KSU_LO = 3;

  // Cause bit positions
  localparam int unsigned CA_DC     = 27;
  localparam int unsigned CA_IV     = 23;
  localparam int unsigned CA_WP     = 22;
  localparam int unsigned CA_IP_LO  = 8;

  // Mirror bit positions
  localparam int unsigned TC_CU_LO  = 28;
  localparam int unsigned TC_MX     = 27;
  localparam int unsigned TC_KSU_LO = 11;
  localparam int unsigned TC_ASID_LO = 0;

  localparam logic [WORD_W-1:0] CA_BASE_WMASK =
    (WORD_W'(1) << CA_IV) | (WORD_W'(1) << CA_WP) |
    (WORD_W'(3) << CA_IP_LO);

  typedef enum logic [1:0] {
    SEL_NONE   = 2'b00,
    SEL_STATUS = 2'b01,
    SEL_CAUSE  = 2'b10,
    SEL_RSVD   = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic stop;
    logic start;
  } cnt_ctl_t;

endpackage

// File: rtl/stat_wr_filter.sv
module stat_wr_filter
  import priv_ctl_pkg::*;
(
  input  logic [WORD_W-1:0] old_val,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] wmask,
  input  logic              r6,
  input  logic              super_ok,
  input  logic              wide64,
  output logic [WORD_W-1:0] new_val,
  output logic              flush_req
);

  logic [WORD_W-1:0] data_adj;
  logic [WORD_W-1:0] mask_adj;
  logic [2:0]        seg_old;
  logic [2:0]        seg_new;
  logic              kx_w;
  logic              sx_w;
  logic              ux_w;

  // Chained segment enables: a lower level needs the one above it.
  always_comb begin
    kx_w = wdata[ST_KX];
    sx_w = wdata[ST_SX] & kx_w;
    ux_w = wdata[ST_UX] & sx_w;
    data_adj = wdata;
    if (r6 && wide64) begin
      data_adj[ST_KX] = kx_w;
      data_adj[ST_SX] = sx_w;
      data_adj[ST_UX] = ux_w;
    end
  end

  // Release-6 narrowing of the writable mask.
  always_comb begin
    mask_adj = wmask;
    if (r6) begin
      if (super_ok && (data_adj[ST_KSU_LO+1:ST_KSU_LO] == 2'b11)) begin
        mask_adj[ST_KSU_LO+1:ST_KSU_LO] = 2'b00;
      end
      if (data_adj[ST_SR]) begin
        mask_adj[ST_SR] = 1'b0;
      end
      if (data_adj[ST_NMI]) begin
        mask_adj[ST_NMI] = 1'b0;
      end
    end
  end

  always_comb begin
    new_val   = (old_val & ~mask_adj) | (data_adj & mask_adj);
    seg_old   = old_val[ST_KX:ST_UX];
    seg_new   = new_val[ST_KX:ST_UX];
    flush_req = |(seg_old & ~seg_new);
  end

endmodule

// File: rtl/cause_wr_filter.sv
module cause_wr_filter
  import priv_ctl_pkg::*;
(
  input  logic [WORD_W-1:0]  old_val,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               r2,
  input  logic               r6,
  output logic [WORD_W-1:0]  new_val,
  output cnt_ctl_t           cnt_evt,
  output logic [NUM_SWI-1:0] swi_chg
);

  logic [WORD_W-1:0] mask_adj;
  logic [WORD_W-1:0] diff;

  always_comb begin
    mask_adj = CA_BASE_WMASK;
    if (r2) begin
      mask_adj[CA_DC] = 1'b1;
    end
    if (r6 && wdata[CA_WP]) begin
      mask_adj[CA_WP] = 1'b0;
    end
    new_val = (old_val & ~mask_adj) | (wdata & mask_adj);
    diff    = old_val ^ new_val;
    cnt_evt.stop  = diff[CA_DC] & new_val[CA_DC];
    cnt_evt.start = diff[CA_DC] & ~new_val[CA_DC];
  end

  for (genvar g = 0; g < NUM_SWI; g++) begin : g_swi
    assign swi_chg[g] = diff[CA_IP_LO+g];
  end

endmodule

// File: rtl/tc_mirror_merge.sv
module tc_mirror_merge
  import priv_ctl_pkg::*;
(
  input  logic [WORD_W-1:0] mirror_old,
  input  logic [WORD_W-1:0] status_new,
  input  logic [ASID_W-1:0] asid,
  output logic [WORD_W-1:0] mirror_new
);

  always_comb begin
    mirror_new = mirror_old;
    mirror_new[TC_CU_LO+3:TC_CU_LO]   = status_new[ST_CU_LO+3:ST_CU_LO];
    mirror_new[TC_MX]                 = status_new[ST_MX];
    mirror_new[TC_KSU_LO+1:TC_KSU_LO] = status_new[ST_KSU_LO+1:ST_KSU_LO];
    mirror_new[TC_ASID_LO+ASID_W-1:TC_ASID_LO] = asid;
  end

endmodule

// File: rtl/priv_ctl_regs.sv
module priv_ctl_regs
  import priv_ctl_pkg::*;
#(
  parameter logic [31:0] STATUS_RST = 32'h0000_0000,
  parameter logic [31:0] CAUSE_RST  = 32'h0000_0000,
  parameter logic [31:0] MIRROR_RST = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        cfg_r6,
  input  logic        cfg_r2,
  input  logic        cfg_super,
  input  logic        cfg_64,
  input  logic [31:0] cfg_status_wmask,
  input  logic [7:0]  asid_in,
  output logic [31:0] status_q,
  output logic [31:0] cause_q,
  output logic [31:0] tc_status_q,
  output logic        count_stop,
  output logic        count_start,
  output logic [1:0]  swi_req,
  output logic        tlb_flush
);

  logic [WORD_W-1:0]  status_r, status_d, status_calc;
  logic [WORD_W-1:0]  cause_r, cause_d, cause_calc;
  logic [WORD_W-1:0]  mirror_r, mirror_d, mirror_calc;
  logic [NUM_SWI-1:0] swi_r, swi_d, swi_chg;
  cnt_ctl_t           cnt_r, cnt_d, cnt_evt;
  logic               flush_r, flush_d, flush_req;
  logic               st_we, ca_we;
  reg_sel_e           sel;

  assign sel   = reg_sel_e'(wr_sel);
  assign st_we = wr_en && (sel == SEL_STATUS);
  assign ca_we = wr_en && (sel == SEL_CAUSE);

  stat_wr_filter u_stat (
    .old_val  (status_r),
    .wdata    (wr_data),
    .wmask    (cfg_status_wmask),
    .r6       (cfg_r6),
    .super_ok (cfg_super),
    .wide64   (cfg_64),
    .new_val  (status_calc),
    .flush_req(flush_req)
  );

  cause_wr_filter u_cause (
    .old_val(cause_r),
    .wdata  (wr_data),
    .r2     (cfg_r2),
    .r6     (cfg_r6),
    .new_val(cause_calc),
    .cnt_evt(cnt_evt),
    .swi_chg(swi_chg)
  );

  tc_mirror_merge u_mirror (
    .mirror_old(mirror_r),
    .status_new(status_calc),
    .asid      (asid_in),
    .mirror_new(mirror_calc)
  );

  // Next state
  always_comb begin
    status_d    = st_we ? status_calc : status_r;
    mirror_d    = st_we ? mirror_calc : mirror_r;
    flush_d     = st_we & flush_req;
    cause_d     = ca_we ? cause_calc : cause_r;
    cnt_d.stop  = ca_we & cnt_evt.stop;
    cnt_d.start = ca_we & cnt_evt.start;
  end

  for (genvar g = 0; g < NUM_SWI; g++) begin : g_swi_nxt
    assign swi_d[g] = (ca_we && swi_chg[g]) ? cause_calc[CA_IP_LO+g] : swi_r[g];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_r <= STATUS_RST;
      cause_r  <= CAUSE_RST;
      mirror_r <= MIRROR_RST;
      swi_r    <= '0;
      cnt_r    <= '0;
      flush_r  <= 1'b0;
    end else begin
      if (st_we) begin
        status_r <= status_d;
        mirror_r <= mirror_d;
      end
      if (ca_we) begin
        cause_r <= cause_d;
        swi_r   <= swi_d;
      end
      cnt_r   <= cnt_d;
      flush_r <= flush_d;
    end
  end

  assign status_q    = status_r;
  assign cause_q     = cause_r;
  assign tc_status_q = mirror_r;
  assign count_stop  = cnt_r.stop;
  assign count_start = cnt_r.start;
  assign swi_req     = swi_r;
  assign tlb_flush   = flush_r;

endmodule

// File: rtl/priv_ctl_regs_chk.sv
module priv_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        cfg_r6,
  input logic        cfg_r2,
  input logic        cfg_super,
  input logic        cfg_64,
  input logic [31:0] cfg_status_wmask,
  input logic [7:0]  asid_in,
  input logic [31:0] status_q,
  input logic [31:0] cause_q,
  input logic [31:0] tc_status_q,
  input logic        count_stop,
  input logic        count_start,
  input logic [1:0]  swi_req,
  input logic        tlb_flush
);

  localparam logic [31:0] CA_ANY_W = 32'h08C0_0300;

  logic st_w, ca_w;
  assign st_w = wr_en && (wr_sel == 2'b01);
  assign ca_w = wr_en && (wr_sel == 2'b10);

  // R2
  a_r2_fixed_cause_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ca_w |=> (((cause_q ^ $past(cause_q)) & ~CA_ANY_W) == 32'h0));

  // R3
  a_r3_wp_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_w && cfg_r6 && !cause_q[22]) |=> !cause_q[22]);

  // R4
  a_r4_cnt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(count_stop && count_start));

  a_r4_stop_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    count_stop |-> (cause_q[27] && $past(ca_w)));

  // R7
  a_r7_sr_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && cfg_r6 && !status_q[20]) |=> !status_q[20]);

  // R8
  a_r8_ksu_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w && cfg_r6 && cfg_super && (wr_data[4:3] == 2'b11)) |=> $stable(status_q[4:3]));

  // R10
  a_r10_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> (($past(status_q[7:5]) & ~status_q[7:5]) != 3'b000));

  // R11
  a_r11_mirror_asid: assert property (@(posedge clk) disable iff (!rst_n)
    st_w |=> (tc_status_q[7:0] == $past(asid_in)));

  // R12
  a_r12_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !st_w |=> ($stable(status_q) && $stable(tc_status_q) && !tlb_flush));

  a_r12_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ca_w |=> ($stable(cause_q) && $stable(swi_req) && !count_stop && !count_start));

endmodule

bind priv_ctl_regs priv_ctl_regs_chk i_priv_ctl_regs_chk (.*);

// File: tb/test_priv_ctl_regs.sv
`timescale 1ns/1ps
module test_priv_ctl_regs;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        cfg_r6, cfg_r2, cfg_super, cfg_64;
  logic [31:0] cfg_status_wmask;
  logic [7:0]  asid_in;
  logic [31:0] status_q, cause_q, tc_status_q;
  logic        count_stop, count_start, tlb_flush;
  logic [1:0]  swi_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  priv_ctl_regs #(
    .STATUS_RST(32'h0018_00E0),
    .CAUSE_RST (32'h0040_0000),
    .MIRROR_RST(32'h0000_0000)
  ) i_priv_ctl_regs (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'b00; wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_q, 32'h0018_00E0);
    chk("R1 cause", cause_q, 32'h0040_0000);
    chk("R1 mirror", tc_status_q, 32'h0);
    chk("R1 pulses", {count_stop, count_start, swi_req, tlb_flush}, 32'h0);
  endtask

  task automatic t_cause();
    cfg_r6 = 1; cfg_r2 = 1;
    wr(2'b10, 32'hFFFF_FFFF);
    chk("R2 cause mask", cause_q, 32'h08C0_0300);
    chk("R4 stop", {count_stop, count_start}, 32'h2);
    chk("R5 swi set", swi_req, 32'h3);
    @(negedge clk);
    chk("R4 stop one cycle", {count_stop, count_start}, 32'h0);
    wr(2'b10, 32'h0);
    chk("R3 wp clear", cause_q, 32'h0);
    chk("R4 start", {count_stop, count_start}, 32'h1);
    chk("R5 swi clear", swi_req, 32'h0);
    wr(2'b10, 32'h0040_0000);
    chk("R3 wp no set", cause_q, 32'h0);
    chk("R4 no pulse", {count_stop, count_start}, 32'h0);
    cfg_r2 = 0;
    wr(2'b10, 32'h0800_0100);
    chk("R2 dc locked", cause_q, 32'h0000_0100);
    chk("R5 swi0", swi_req, 32'h1);
    chk("R4 no pulse r2off", {count_stop, count_start}, 32'h0);
    cfg_r6 = 0;
    wr(2'b10, 32'h0040_0000);
    chk("R3 wp set pre-r6", cause_q, 32'h0040_0000);
    chk("R5 swi0 off", swi_req, 32'h0);
    cfg_r6 = 1; cfg_r2 = 1;
  endtask

  task automatic t_status_rules();
    wr(2'b01, 32'h0018_00F8);
    chk("R8 ksu refused", status_q, 32'h0018_00E0);
    chk("R11 mirror", tc_status_q, 32'h0000_005A);
    chk("R10 no flush", tlb_flush, 32'h0);
    cfg_super = 0;
    wr(2'b01, 32'h0018_00F8);
    chk("R8 ksu no super", status_q, 32'h0018_00F8);
    chk("R11 mirror ksu", tc_status_q, 32'h0000_185A);
    cfg_super = 1;
    wr(2'b01, 32'h0000_00F8);
    chk("R7 sr nmi clear", status_q, 32'h0000_00F8);
    wr(2'b01, 32'h0018_00F8);
    chk("R7 sr nmi no set", status_q, 32'h0000_00F8);
    cfg_r6 = 0;
    wr(2'b01, 32'h0018_00F8);
    chk("R7 set pre-r6", status_q, 32'h0018_00F8);
  endtask

  task automatic t_status_mask();
    cfg_r6 = 0;
    wr(2'b01, 32'hFFFF_FFFF);
    chk("R6 mask", status_q, 32'hF118_00FF);
    chk("R11 mirror full", tc_status_q, 32'hF800_185A);
    chk("R10 no flush set", tlb_flush, 32'h0);
    asid_in = 8'hC3;
    wr(2'b01, 32'h0);
    chk("R6 clear", status_q, 32'h0);
    chk("R10 flush", tlb_flush, 32'h1);
    chk("R11 mirror asid", tc_status_q, 32'h0000_00C3);
    @(negedge clk);
    chk("R10 flush one cycle", tlb_flush, 32'h0);
    cfg_r6 = 1;
  endtask

  task automatic t_chain();
    cfg_r6 = 1; cfg_64 = 1;
    wr(2'b01, 32'h0000_00E0);
    chk("R9 all set", status_q, 32'h0000_00E0);
    wr(2'b01, 32'h0000_0060);
    chk("R9 chain kx", status_q, 32'h0);
    chk("R10 flush chain", tlb_flush, 32'h1);
    wr(2'b01, 32'h0000_00A0);
    chk("R9 chain sx", status_q, 32'h0000_0080);
    chk("R10 no flush rise", tlb_flush, 32'h0);
    cfg_64 = 0;
    wr(2'b01, 32'h0000_0060);
    chk("R9 no chain 32b", status_q, 32'h0000_0060);
    chk("R10 flush kx", tlb_flush, 32'h1);
    cfg_64 = 1;
  endtask

  task automatic t_ignored();
    logic [31:0] s0, c0, m0;
    s0 = status_q; c0 = cause_q; m0 = tc_status_q;
    wr(2'b00, 32'hFFFF_FFFF);
    chk("R12 sel00 status", status_q, s0);
    chk("R12 sel00 cause", cause_q, c0);
    wr(2'b11, 32'hFFFF_FFFF);
    chk("R12 sel11 status", status_q, s0);
    chk("R12 sel11 cause", cause_q, c0);
    chk("R12 sel11 mirror", tc_status_q, m0);
    chk("R12 sel11 side", {count_stop, count_start, swi_req, tlb_flush}, 32'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    cfg_r6 = 1; cfg_r2 = 1; cfg_super = 1; cfg_64 = 1;
    cfg_status_wmask = 32'hF118_00FF;
    asid_in = 8'h5A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cause();
    t_status_rules();
    t_status_mask();
    t_chain();
    t_ignored();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule